// File: doc/BRIEF.md
# Rotate, Shift and Bit-Test Unit

This unit carries out the byte rotate, shift, nibble-rotate and single-bit operations of an 8-bit accumulator-style processor core. On each cycle where `op_valid_i` is high it samples an operation code, the operand byte, the accumulator, the current flag byte, a 3-bit bit index and a memory-source indicator. One clock later it presents the result byte, the new accumulator and the new flag byte, and pulses `done_o`. When no strobe arrives, the registered outputs hold their values.

Two families of rotate share datapath logic but treat flags differently. The short accumulator rotates keep sign, zero and parity. The prefixed rotates and shifts recompute every flag from the result. The unit also covers the two nibble rotates, which combine the accumulator with a memory byte, and the bit test, set and reset operations. For a bit test whose operand comes from memory, flag bits 5 and 3 are taken from the high byte of a 16-bit internal address latch instead of from the operand.

Top module: `rsb_unit`

## Requirements
- R1: After rst_ni is asserted (low) and released, result_o, acc_o and flags_o read 0x00 and done_o reads 0 until the first strobe.
- R2: An operation sampled with op_valid_i high appears on result_o, acc_o and flags_o on the next rising edge, together with a one-cycle done_o pulse. Without a strobe all three outputs hold and done_o is 0.
- R3: Flag byte layout is S=bit7, Z=bit6, F5=bit5, H=bit4, F3=bit3, PV=bit2, N=bit1, C=bit0. The accumulator rotates use op codes 0 (rotate left circular), 1 (rotate right circular), 2 (rotate left through carry) and 3 (rotate right through carry). They act on acc_i and put the rotated value on both result_o and acc_o. C receives the bit shifted out, H and N are cleared, F5 and F3 come from the new value, and S, Z and PV are copied from flags_i.
- R4: The prefixed rotates act on operand_i and leave acc_o equal to acc_i. Op code 4 rotates left circular, 5 rotates right circular, 6 rotates left with the old C shifted in, and 7 rotates right with the old C shifted in.
- R5: The shifts act on operand_i. Op code 8 shifts left with 0 filled in. Op code 9 shifts right and keeps bit 7. Op code 10 shifts left and forces bit 0 to 1. Op code 11 shifts right with 0 filled in.
- R6: For op codes 4 to 11, S, F5 and F3 are the matching result bits, Z is set when the result is zero, PV is set when the result has an even number of ones, H and N are cleared, and C is the bit shifted out.
- R7: Op code 12 (nibble rotate left): the new A is {acc_i[7:4], operand_i[7:4]} and result_o is {operand_i[3:0], acc_i[3:0]}. Op code 13 (nibble rotate right): the new A is {acc_i[7:4], operand_i[3:0]} and result_o is {acc_i[3:0], operand_i[7:4]}. S, Z, F5, F3 and PV come from the new A as in R6, H and N are cleared, and C is kept.
- R8: Op code 14 (bit test) tests operand_i[bit_sel_i]. Z and PV are set when that bit is 0, S is bit 7 of the operand masked to the tested bit, H is set, N is cleared, and C is kept. result_o equals operand_i and acc_o equals acc_i.
- R9: For the bit test, F5 and F3 are operand_i[5] and operand_i[3] when mem_src_i is 0, and addr_latch_i[13] and addr_latch_i[11] when mem_src_i is 1.
- R10: Op code 15 clears and op code 16 sets operand_i[bit_sel_i] on result_o, leaving every other bit of the operand and the whole of flags_i unchanged.
- R11: Op codes 17 to 31 have no effect: result_o equals operand_i, acc_o equals acc_i and flags_o equals flags_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_valid_i | input | 1 | Operation strobe |
| op_i | input | 5 | Operation code (see requirements) |
| operand_i | input | 8 | Register or memory operand |
| acc_i | input | 8 | Current accumulator |
| flags_i | input | 8 | Current flag byte |
| bit_sel_i | input | 3 | Bit index for test, set and clear |
| mem_src_i | input | 1 | Operand comes from memory or an indexed address |
| addr_latch_i | input | 16 | Internal address latch |
| result_o | output | 8 | Result byte |
| acc_o | output | 8 | New accumulator |
| flags_o | output | 8 | New flag byte |
| done_o | output | 1 | Result valid pulse |

## Verification
The hardest case to reach from the ports is a stale flag leaking through. A bit test must keep C, and an accumulator rotate must keep S, Z and PV. A fault in either only shows up when flags_i carries values that differ from what a fresh computation would produce. The stimulus therefore drives flag bytes of all ones, all zeros and random values against operands whose own S, Z and parity disagree with them. For the bit test it pairs a register source and a memory source with an address latch whose bits 13 and 11 differ from operand bits 5 and 3.

// File: rtl/rsb_pkg.sv
package rsb_pkg;

  localparam int unsigned DATA_W = 8;
  localparam int unsigned ADDR_W = 16;

  // flag byte bit positions
  localparam int unsigned FLG_C  = 0;
  localparam int unsigned FLG_N  = 1;
  localparam int unsigned FLG_PV = 2;
  localparam int unsigned FLG_F3 = 3;
  localparam int unsigned FLG_H  = 4;
  localparam int unsigned FLG_F5 = 5;
  localparam int unsigned FLG_Z  = 6;
  localparam int unsigned FLG_S  = 7;

  typedef enum logic [4:0] {
    OP_RLCA = 5'd0,
    OP_RRCA = 5'd1,
    OP_RLA  = 5'd2,
    OP_RRA  = 5'd3,
    OP_RLC  = 5'd4,
    OP_RRC  = 5'd5,
    OP_RL   = 5'd6,
    OP_RR   = 5'd7,
    OP_SLA  = 5'd8,
    OP_SRA  = 5'd9,
    OP_SLL  = 5'd10,
    OP_SRL  = 5'd11,
    OP_RLD  = 5'd12,
    OP_RRD  = 5'd13,
    OP_BIT  = 5'd14,
    OP_RES  = 5'd15,
    OP_SET  = 5'd16
  } op_e;

  // full flag byte from a value: S Z F5 F3 PV set, H N cleared, C given
  function automatic logic [7:0] value_flags(input logic [7:0] v, input logic c);
    logic [7:0] f;
    f          = '0;
    f[FLG_S]   = v[7];
    f[FLG_Z]   = (v == 8'h00);
    f[FLG_F5]  = v[5];
    f[FLG_F3]  = v[3];
    f[FLG_PV]  = ~^v;
    f[FLG_C]   = c;
    return f;
  endfunction

endpackage

// File: rtl/rsb_shifter.sv
module rsb_shifter
  import rsb_pkg::*;
#(
  parameter int unsigned DW = DATA_W
) (
  input  op_e           op_i,
  input  logic [DW-1:0] acc_i,
  input  logic [DW-1:0] operand_i,
  input  logic          cin_i,
  output logic [DW-1:0] res_o,
  output logic          cout_o
);

  logic          go_left;
  logic          fill;
  logic          use_acc;
  logic [DW-1:0] src;

  always_comb begin
    go_left = 1'b1;
    fill    = 1'b0;
    use_acc = 1'b0;
    unique case (op_i)
      OP_RLCA: begin use_acc = 1'b1; go_left = 1'b1; fill = acc_i[DW-1]; end
      OP_RRCA: begin use_acc = 1'b1; go_left = 1'b0; fill = acc_i[0];    end
      OP_RLA:  begin use_acc = 1'b1; go_left = 1'b1; fill = cin_i;       end
      OP_RRA:  begin use_acc = 1'b1; go_left = 1'b0; fill = cin_i;       end
      OP_RLC:  begin go_left = 1'b1; fill = operand_i[DW-1]; end
      OP_RRC:  begin go_left = 1'b0; fill = operand_i[0];    end
      OP_RL:   begin go_left = 1'b1; fill = cin_i;           end
      OP_RR:   begin go_left = 1'b0; fill = cin_i;           end
      OP_SLA:  begin go_left = 1'b1; fill = 1'b0;            end
      OP_SRA:  begin go_left = 1'b0; fill = operand_i[DW-1]; end
      OP_SLL:  begin go_left = 1'b1; fill = 1'b1;            end
      OP_SRL:  begin go_left = 1'b0; fill = 1'b0;            end
      default: begin go_left = 1'b1; fill = 1'b0;            end
    endcase
  end

  assign src = use_acc ? acc_i : operand_i;

  always_comb begin
    if (go_left) begin
      res_o  = {src[DW-2:0], fill};
      cout_o = src[DW-1];
    end else begin
      res_o  = {fill, src[DW-1:1]};
      cout_o = src[0];
    end
  end

endmodule

// File: rtl/rsb_nibble.sv
module rsb_nibble
  import rsb_pkg::*;
#(
  parameter int unsigned DW = DATA_W
) (
  input  logic          left_i,
  input  logic [DW-1:0] acc_i,
  input  logic [DW-1:0] mem_i,
  output logic [DW-1:0] acc_o,
  output logic [DW-1:0] mem_o
);

  localparam int unsigned NW = DW / 2;

  logic [NW-1:0] a_hi, a_lo, m_hi, m_lo;

  assign a_hi = acc_i[DW-1:NW];
  assign a_lo = acc_i[NW-1:0];
  assign m_hi = mem_i[DW-1:NW];
  assign m_lo = mem_i[NW-1:0];

  // three nibbles rotate; the accumulator high nibble stays put
  always_comb begin
    if (left_i) begin
      acc_o = {a_hi, m_hi};
      mem_o = {m_lo, a_lo};
    end else begin
      acc_o = {a_hi, m_lo};
      mem_o = {a_lo, m_hi};
    end
  end

endmodule

// File: rtl/rsb_bitop.sv
module rsb_bitop
  import rsb_pkg::*;
#(
  parameter int unsigned DW = DATA_W,
  parameter int unsigned AW = ADDR_W
) (
  input  logic [DW-1:0]         operand_i,
  input  logic [$clog2(DW)-1:0] bit_sel_i,
  input  logic                  mem_src_i,
  input  logic [AW-1:0]         addr_latch_i,
  output logic [DW-1:0]         masked_o,
  output logic                  hit_o,
  output logic [DW-1:0]         set_o,
  output logic [DW-1:0]         clr_o,
  output logic [DW-1:0]         leak_o
);

  localparam int unsigned SW = $clog2(DW);

  logic [DW-1:0] onehot;
  logic          unused_latch_lo;

  for (genvar gi = 0; gi < DW; gi++) begin : g_dec
    assign onehot[gi] = (bit_sel_i == SW'(gi));
  end

  assign masked_o = operand_i & onehot;
  assign hit_o    = |masked_o;
  assign set_o    = operand_i | onehot;
  assign clr_o    = operand_i & ~onehot;

  // memory or indexed source: undocumented bits follow the latch high byte
  assign leak_o = mem_src_i ? addr_latch_i[AW-1:AW-DW] : operand_i;

  assign unused_latch_lo = ^addr_latch_i[AW-DW-1:0];

endmodule

// File: rtl/rsb_unit.sv
module rsb_unit
  import rsb_pkg::*;
#(
  parameter int unsigned DW = DATA_W,
  parameter int unsigned AW = ADDR_W
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  op_valid_i,
  input  logic [4:0]            op_i,
  input  logic [DW-1:0]         operand_i,
  input  logic [DW-1:0]         acc_i,
  input  logic [7:0]            flags_i,
  input  logic [$clog2(DW)-1:0] bit_sel_i,
  input  logic                  mem_src_i,
  input  logic [AW-1:0]         addr_latch_i,
  output logic [DW-1:0]         result_o,
  output logic [DW-1:0]         acc_o,
  output logic [7:0]            flags_o,
  output logic                  done_o
);

  op_e           op;
  logic [DW-1:0] sh_res;
  logic          sh_cout;
  logic [DW-1:0] nb_acc, nb_mem;
  logic [DW-1:0] bt_masked, bt_set, bt_clr, bt_leak;
  logic          bt_hit;

  logic [DW-1:0] res_d, acc_d;
  logic [7:0]    flags_d;
  logic [DW-1:0] res_q, acc_q;
  logic [7:0]    flags_q;
  logic          done_q;

  assign op = op_e'(op_i);

  rsb_shifter #(.DW(DW)) u_shift (
    .op_i      (op),
    .acc_i     (acc_i),
    .operand_i (operand_i),
    .cin_i     (flags_i[FLG_C]),
    .res_o     (sh_res),
    .cout_o    (sh_cout)
  );

  rsb_nibble #(.DW(DW)) u_nib (
    .left_i (op == OP_RLD),
    .acc_i  (acc_i),
    .mem_i  (operand_i),
    .acc_o  (nb_acc),
    .mem_o  (nb_mem)
  );

  rsb_bitop #(.DW(DW), .AW(AW)) u_bit (
    .operand_i    (operand_i),
    .bit_sel_i    (bit_sel_i),
    .mem_src_i    (mem_src_i),
    .addr_latch_i (addr_latch_i),
    .masked_o     (bt_masked),
    .hit_o        (bt_hit),
    .set_o        (bt_set),
    .clr_o        (bt_clr),
    .leak_o       (bt_leak)
  );

  always_comb begin
    res_d   = operand_i;
    acc_d   = acc_i;
    flags_d = flags_i;
    case (op)
      OP_RLCA, OP_RRCA, OP_RLA, OP_RRA: begin
        // short forms: S, Z, PV pass through
        res_d           = sh_res;
        acc_d           = sh_res;
        flags_d[FLG_C]  = sh_cout;
        flags_d[FLG_H]  = 1'b0;
        flags_d[FLG_N]  = 1'b0;
        flags_d[FLG_F5] = sh_res[5];
        flags_d[FLG_F3] = sh_res[3];
      end
      OP_RLC, OP_RRC, OP_RL, OP_RR, OP_SLA, OP_SRA, OP_SLL, OP_SRL: begin
        res_d   = sh_res;
        flags_d = value_flags(sh_res, sh_cout);
      end
      OP_RLD, OP_RRD: begin
        res_d   = nb_mem;
        acc_d   = nb_acc;
        flags_d = value_flags(nb_acc, flags_i[FLG_C]);
      end
      OP_BIT: begin
        flags_d[FLG_S]  = bt_masked[DW-1];
        flags_d[FLG_Z]  = ~bt_hit;
        flags_d[FLG_PV] = ~bt_hit;
        flags_d[FLG_H]  = 1'b1;
        flags_d[FLG_N]  = 1'b0;
        flags_d[FLG_F5] = bt_leak[5];
        flags_d[FLG_F3] = bt_leak[3];
      end
      OP_RES:  res_d = bt_clr;
      OP_SET:  res_d = bt_set;
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_q   <= '0;
      acc_q   <= '0;
      flags_q <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= op_valid_i;
      if (op_valid_i) begin
        res_q   <= res_d;
        acc_q   <= acc_d;
        flags_q <= flags_d;
      end
    end
  end

  assign result_o = res_q;
  assign acc_o    = acc_q;
  assign flags_o  = flags_q;
  assign done_o   = done_q;

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_valid_i |=> done_o) else $error("strobe without done"); // R2

  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !op_valid_i |=> (!done_o && $stable(result_o) && $stable(acc_o) && $stable(flags_o)))
    else $error("outputs moved without strobe"); // R2

  AST_SHORT_ROT_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && op_i <= 5'd3) |=>
      (flags_o[FLG_S] == $past(flags_i[FLG_S]) && flags_o[FLG_Z] == $past(flags_i[FLG_Z])
       && flags_o[FLG_PV] == $past(flags_i[FLG_PV]) && acc_o == result_o))
    else $error("short rotate touched S/Z/PV"); // R3

  AST_SHIFT_ZP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && op_i >= 5'd4 && op_i <= 5'd11) |=>
      (flags_o[FLG_Z] == (result_o == '0) && flags_o[FLG_PV] == ~^result_o
       && !flags_o[FLG_H] && !flags_o[FLG_N] && acc_o == $past(acc_i)))
    else $error("shift flags inconsistent with result"); // R6

  AST_NIBBLE_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && (op_i == 5'd12 || op_i == 5'd13)) |=>
      (acc_o[DW-1:DW/2] == $past(acc_i[DW-1:DW/2]) && flags_o[FLG_C] == $past(flags_i[FLG_C])))
    else $error("nibble rotate disturbed A high nibble or C"); // R7

  AST_BIT_FIXED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && op_i == 5'd14) |=>
      (flags_o[FLG_H] && !flags_o[FLG_N] && flags_o[FLG_Z] == flags_o[FLG_PV]
       && flags_o[FLG_C] == $past(flags_i[FLG_C]) && result_o == $past(operand_i)))
    else $error("bit test flag rule broken"); // R8

  AST_BIT_LEAK_MEM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && op_i == 5'd14 && mem_src_i) |=>
      (flags_o[FLG_F5] == $past(addr_latch_i[AW-DW+5]) && flags_o[FLG_F3] == $past(addr_latch_i[AW-DW+3])))
    else $error("latch leak missing"); // R9

  AST_SETCLR_ONE_BIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && (op_i == 5'd15 || op_i == 5'd16)) |=>
      ($countones(result_o ^ $past(operand_i)) <= 1 && flags_o == $past(flags_i)))
    else $error("set/clear touched more than one bit or flags"); // R10

  AST_UNDEF_NOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && op_i >= 5'd17) |=>
      (result_o == $past(operand_i) && acc_o == $past(acc_i) && flags_o == $past(flags_i)))
    else $error("undefined op had effect"); // R11

endmodule

// File: tb/sim_rsb_unit.sv
`timescale 1ns/1ps
module sim_rsb_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        vld = 1'b0;
  logic [4:0]  op = '0;
  logic [7:0]  opd = '0, acc = '0, flg = '0;
  logic [2:0]  bsel = '0;
  logic        msrc = 1'b0;
  logic [15:0] lat = '0;
  logic [7:0]  res_w, acc_w, flg_w;
  logic        done_w;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  logic [7:0] e_res = 0, e_acc = 0, e_flg = 0;
  logic       e_done = 0;
  string      e_tag = "R1";

  always #2.5 clk = ~clk;

  rsb_unit u0 (
    .clk_i(clk), .rst_ni(rst_n), .op_valid_i(vld), .op_i(op),
    .operand_i(opd), .acc_i(acc), .flags_i(flg), .bit_sel_i(bsel),
    .mem_src_i(msrc), .addr_latch_i(lat),
    .result_o(res_w), .acc_o(acc_w), .flags_o(flg_w), .done_o(done_w)
  );

  function automatic int even_ones(input int v);
    int n = 0;
    for (int i = 0; i < 8; i++) n += (v >> i) & 1;
    return ((n % 2) == 0) ? 1 : 0;
  endfunction

  // S Z F5 F3 PV from v, H=N=0, C given
  function automatic int full_flags(input int v, input int c);
    int f = 0;
    if (v & 8'h80) f += 128;
    if (v == 0)    f += 64;
    f += v & 8'h28;
    if (even_ones(v) != 0) f += 4;
    f += c & 1;
    return f;
  endfunction

  function automatic string tag_of(input int o);
    if (o <= 3)  return "R3";
    if (o <= 7)  return "R4/R6";
    if (o <= 11) return "R5/R6";
    if (o <= 13) return "R7";
    if (o == 14) return "R8/R9";
    if (o <= 16) return "R10";
    return "R11";
  endfunction

  // returns {result, acc, flags}
  function automatic logic [23:0] model(input int o, input int m, input int a, input int f,
                                         input int b, input int ms, input int la);
    int r = m, na = a, nf = f, c = 0, cin = f & 1, t;
    case (o)
      0: begin c = (a >> 7) & 1; r = ((a << 1) | c) & 255; end
      1: begin c = a & 1; r = (a >> 1) | (c << 7); end
      2: begin c = (a >> 7) & 1; r = ((a << 1) | cin) & 255; end
      3: begin c = a & 1; r = (a >> 1) | (cin << 7); end
      4: begin c = (m >> 7) & 1; r = ((m << 1) | c) & 255; end
      5: begin c = m & 1; r = (m >> 1) | (c << 7); end
      6: begin c = (m >> 7) & 1; r = ((m << 1) | cin) & 255; end
      7: begin c = m & 1; r = (m >> 1) | (cin << 7); end
      8: begin c = (m >> 7) & 1; r = (m << 1) & 255; end
      9: begin c = m & 1; r = (m >> 1) | (m & 128); end
      10: begin c = (m >> 7) & 1; r = ((m << 1) | 1) & 255; end
      11: begin c = m & 1; r = m >> 1; end
      default: ;
    endcase
    if (o <= 3) begin
      na = r;
      nf = (f & 8'hC4) | (r & 8'h28) | c;
    end else if (o <= 11) begin
      nf = full_flags(r, c);
    end else if (o == 12) begin
      na = (a & 8'hF0) | (m >> 4);
      r  = ((m << 4) | (a & 15)) & 255;
      nf = full_flags(na, cin);
    end else if (o == 13) begin
      na = (a & 8'hF0) | (m & 15);
      r  = ((a & 15) << 4) | (m >> 4);
      nf = full_flags(na, cin);
    end else if (o == 14) begin
      t  = m & (1 << b);
      nf = (t & 128) | 16 | cin;
      if (t == 0) nf += 64 + 4;
      nf += (ms != 0) ? ((la >> 8) & 8'h28) : (m & 8'h28);
    end else if (o == 15) r = m & ~(1 << b) & 255;
    else if (o == 16) r = m | (1 << b);
    return {r[7:0], na[7:0], nf[7:0]};
  endfunction

  task automatic compare();
    checks++;
    if (res_w !== e_res || acc_w !== e_acc || flg_w !== e_flg || done_w !== e_done) begin
      fails++;
      $display("FAIL %s: got res=%02h acc=%02h flg=%02h done=%0b exp res=%02h acc=%02h flg=%02h done=%0b",
               e_tag, res_w, acc_w, flg_w, done_w, e_res, e_acc, e_flg, e_done);
    end
  endtask

  task automatic apply(input bit v, input int o, input int m, input int a, input int f,
                       input int b, input int ms, input int la);
    logic [23:0] x;
    @(negedge clk);
    compare();
    vld = v; op = o[4:0]; opd = m[7:0]; acc = a[7:0]; flg = f[7:0];
    bsel = b[2:0]; msrc = ms[0]; lat = la[15:0];
    e_done = v;
    if (v) begin
      x = model(o, m, a, f, b, ms, la);
      {e_res, e_acc, e_flg} = x;
      e_tag = tag_of(o);
    end else begin
      e_tag = "R2";
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state checked on first compare
    apply(0, 0, 8'h5A, 8'hA5, 8'hFF, 0, 0, 0);
    apply(0, 0, 8'h00, 8'h00, 8'h00, 0, 0, 0);
    // R3 short rotates with inverted-looking flag bytes
    for (int o = 0; o < 4; o++) begin
      apply(1, o, 8'h00, 8'h80, 8'h00, 0, 0, 0);
      apply(1, o, 8'h00, 8'h01, 8'hFF, 0, 0, 0);
      apply(1, o, 8'h00, 8'h00, 8'hC5, 0, 0, 0);
      apply(1, o, 8'h00, 8'h7E, 8'h01, 0, 0, 0);
    end
    // R4 R5 R6 prefixed rotates and shifts, carry in 0 and 1
    for (int o = 4; o < 12; o++) begin
      apply(1, o, 8'h80, 8'h33, 8'h00, 0, 0, 0);
      apply(1, o, 8'h01, 8'h33, 8'hFF, 0, 0, 0);
      apply(1, o, 8'h00, 8'h33, 8'h01, 0, 0, 0);
      apply(1, o, 8'hFF, 8'h33, 8'h00, 0, 0, 0);
      apply(1, o, 8'hA5, 8'h33, 8'h01, 0, 0, 0);
    end
    // R2: idle holds
    apply(0, 5, 8'h12, 8'h34, 8'h56, 0, 0, 0);
    apply(0, 9, 8'h99, 8'h11, 8'h22, 0, 0, 0);
    // R7 nibble rotates
    apply(1, 12, 8'h12, 8'h34, 8'h01, 0, 0, 0);
    apply(1, 13, 8'h12, 8'h34, 8'h00, 0, 0, 0);
    apply(1, 12, 8'h00, 8'h00, 8'hFF, 0, 0, 0);
    apply(1, 13, 8'hF0, 8'h80, 8'h00, 0, 0, 0);
    // R8 R9 bit test, every index, register vs memory source
    for (int b = 0; b < 8; b++) begin
      apply(1, 14, 8'hFF, 8'h00, 8'h00, b, 0, 16'h0000);
      apply(1, 14, 8'h00, 8'h00, 8'hFF, b, 0, 16'hFFFF);
      apply(1, 14, 8'h28 | (1 << b), 8'h00, 8'h01, b, 1, 16'h0000);
      apply(1, 14, 8'h00, 8'h00, 8'h00, b, 1, 16'h28FF);
    end
    // R10 set / clear every index
    for (int b = 0; b < 8; b++) begin
      apply(1, 15, 8'hFF, 8'h12, 8'hA5, b, 0, 0);
      apply(1, 16, 8'h00, 8'h12, 8'h5A, b, 0, 0);
      apply(1, 16, 8'hFF, 8'h12, 8'h00, b, 0, 0);
    end
    // R11 undefined codes
    for (int o = 17; o < 32; o++) apply(1, o, 8'h3C, 8'hC3, 8'h96, 3, 1, 16'hFFFF);
    // mixed random traffic
    for (int i = 0; i < 3000; i++) begin
      apply(($urandom % 5) != 0, $urandom % 32, $urandom % 256, $urandom % 256,
            $urandom % 256, $urandom % 8, $urandom % 2, $urandom % 65536);
    end
    apply(0, 0, 0, 0, 0, 0, 0, 0);
    apply(0, 0, 0, 0, 0, 0, 0, 0);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #(5.0 * 100000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: got running exp finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule